// File: doc/BRIEF.md
# Audio Settings I2C Register Slave

This block is the control front end of a stereo audio processor. It sits on an I2C bus as a slave and keeps ten 8-bit setting registers: precontrol volume, left and right loudspeaker volume, headphone volume, tone, crosstalk compensation and four switching bytes. All ten registers are presented as parallel outputs that drive the analog functions. The bus lines are brought into the system clock domain through two flip-flop synchronisers. START and STOP are detected as SDA edges while SCL is high. The slave drives SDA only through an active-high pull-down enable. The block is meant for SCL rates up to 100 kHz with a much faster system clock.

A write telegram consists of the device address followed by subaddress/data pairs. There is no auto-increment: every data byte needs its own subaddress byte in front of it, and one telegram may carry many pairs. A read returns one status byte. That byte holds the stereo and dual identification flags and a sticky clip flag. Each status capture clears the clip flag. A clip event in the same cycle as the capture survives the clear, so no event is lost.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset every setting register reads 0x01 and the slave does not pull SDA low.
- R2: The slave answers only the 7-bit address 1000010. The write byte is 0x84 and the read byte is 0x85. After any other address byte there is no ACK, and every later byte up to the next START leaves the registers unchanged.
- R3: In a write telegram, the first byte after the address is a subaddress and the next byte is data. The data goes into the register numbered by bits 3:0 of the subaddress, and bits 7:4 of the subaddress are ignored.
- R4: One telegram may carry several subaddress/data pairs for different registers without a repeated START, and every pair is written.
- R5: There is no auto-increment. A byte that follows a data byte is taken as a new subaddress and is not written anywhere.
- R6: A data byte whose subaddress low nibble is 0xA to 0xF is acknowledged and then discarded, and no register changes.
- R7: The read byte is laid out as follows: bit 7 is the stereo flag, bit 6 is the dual flag, bits 5:3 are 0, bit 2 is the clip flag, and bits 1:0 are 0. The flags are captured on the SCL falling edge that ends the address ACK.
- R8: The clip flag is set by a pulse on `clip_evt`. It stays set until a status capture clears it. If a clip pulse arrives in the capture cycle, the flag stays set for the next read.
- R9: The slave pulls SDA low during the ninth clock of every byte it accepts, and it changes SDA only while SCL is low.
- R10: A START always restarts the pairing, so the first byte after the address is treated as a subaddress even if the previous telegram ended after a lone subaddress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the slave pulls SDA low (open-drain) |
| clip_evt | input | 1 | One-cycle pulse: the loudspeaker path hit its clipping limit |
| stereo_det | input | 1 | Stereo identification flag from the decoder |
| dual_det | input | 1 | Dual-sound identification flag from the decoder |
| regs_o | output | 80 | Setting registers; register n occupies bits n*8+7 down to n*8 |

## Verification
Each bus edge passes through two synchroniser stages before the control logic sees it. As a result, a register write appears at `regs_o` at the third clock edge after the SCL rise that carries the last data bit. The bench model applies each write at exactly that edge, and the register outputs are compared with the model on every falling clock edge. The ACK pull-down and each read bit appear three edges after an SCL fall. These are sampled half an SCL period or more later, while SCL is stable. For the clip-collision case, the clip pulse is placed on the third edge after the SCL fall that ends the address ACK, which is the capture edge.

// File: rtl/actl_pkg.sv
package actl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_d  <= scl_sh[SYNC-1];
      sda_d  <= sda_sh[SYNC-1];
    end
  end

  assign scl_s     = scl_sh[SYNC-1];
  assign sda_s     = sda_sh[SYNC-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/actl_byte_fsm.sv
module actl_byte_fsm
  import actl_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1000010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] status_i,
  output logic          sda_oe,
  output logic          byte_stb,
  output logic [DW-1:0] byte_val,
  output logic          status_load
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  bus_st_e       state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          rw;

  assign byte_stb    = (state == ST_WDATA) && scl_rise && (cnt == LAST);
  assign byte_val    = {shreg[DW-2:0], sda_s};
  assign status_load = scl_fall && (((state == ST_AACK) && rw) || (state == ST_RACK));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      sda_oe <= 1'b0;
      rw     <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (status_load) begin
      shreg  <= status_i;
      sda_oe <= ~status_i[DW-1];
      cnt    <= '0;
      state  <= ST_RDATA;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt != FULL) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            if (state == ST_WDATA) begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
            end else if (shreg[DW-1:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= shreg[0];
              state  <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              cnt    <= cnt + 1'b1;
              shreg  <= {shreg[DW-2:0], 1'b0};
              sda_oe <= ~shreg[DW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/actl_reg_bank.sv
module actl_reg_bank #(
  parameter int          DW        = 8,
  parameter int          NREG      = 10,
  parameter int          SUBW      = 4,
  parameter logic [DW-1:0] RST_VAL = 8'h01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_det,
  input  logic               byte_stb,
  input  logic [DW-1:0]      byte_val,
  output logic [NREG*DW-1:0] regs_o
);
  localparam logic [SUBW:0] NREG_W = (SUBW + 1)'(NREG);

  logic [DW-1:0]   mem [NREG];
  logic [SUBW-1:0] sub;
  logic            want_sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub      <= '0;
      want_sub <= 1'b1;
      for (int i = 0; i < NREG; i++) mem[i] <= RST_VAL;
    end else if (start_det) begin
      want_sub <= 1'b1;
    end else if (byte_stb) begin
      if (want_sub) begin
        sub      <= byte_val[SUBW-1:0];
        want_sub <= 1'b0;
      end else begin
        if ({1'b0, sub} < NREG_W) mem[sub] <= byte_val;
        want_sub <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave #(
  parameter int         DW       = 8,
  parameter int         NREG     = 10,
  parameter int         SYNC     = 2,
  parameter logic [6:0] DEV_ADDR = 7'b1000010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               clip_evt,
  input  logic               stereo_det,
  input  logic               dual_det,
  output logic [NREG*DW-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic byte_stb, status_load, clip_q;
  logic [DW-1:0] byte_val, status;

  actl_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign status = {stereo_det, dual_det, 3'b000, clip_q, 2'b00};

  actl_byte_fsm #(.DW(DW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .status_i(status),
    .sda_oe(sda_oe), .byte_stb(byte_stb), .byte_val(byte_val),
    .status_load(status_load)
  );

  actl_reg_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .start_det(start_det), .byte_stb(byte_stb),
    .byte_val(byte_val), .regs_o(regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) clip_q <= 1'b0;
    else     clip_q <= clip_evt | (clip_q & ~status_load);
  end
endmodule

// File: rtl/actl_checker.sv
module actl_checker #(
  parameter int W = 80
) (
  input logic         clk,
  input logic         rst,
  input logic         clip_evt,
  input logic         clip_q,
  input logic         status_load,
  input logic         byte_stb,
  input logic         stop_det,
  input logic         scl_s,
  input logic         sda_oe,
  input logic [W-1:0] regs_o
);
  AST_CLIP_SET_HOLDS: assert property (@(posedge clk) disable iff (rst) clip_evt |=> clip_q); // R8
  AST_CLIP_CLEARED_ON_READ: assert property (@(posedge clk) disable iff (rst) (status_load && !clip_evt) |=> !clip_q); // R8
  AST_REGS_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (rst) !byte_stb |=> $stable(regs_o)); // R3
  AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_s); // R9
  AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe); // R9
endmodule

bind audio_ctl_i2c_slave actl_checker #(.W(NREG*DW)) u_chk (
  .clk(clk), .rst(rst), .clip_evt(clip_evt), .clip_q(clip_q),
  .status_load(status_load), .byte_stb(byte_stb), .stop_det(stop_det),
  .scl_s(scl_s), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/tb_audio_ctl_i2c_slave.sv
`timescale 1ns/1ps
module tb_audio_ctl_i2c_slave;
  localparam int NREG = 10;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic clip_evt = 1'b0, stereo_det = 1'b0, dual_det = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  logic [7:0] exp_r [NREG];
  bit exp_sub = 1'b1, active = 1'b0, exp_clip = 1'b0, done = 1'b0;
  logic [7:0] sub_m = 8'h00;

  always #5 clk = ~clk;

  audio_ctl_i2c_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .clip_evt(clip_evt), .stereo_det(stereo_det), .dual_det(dual_det), .regs_o(regs_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      for (int i = 0; i < NREG; i++) begin
        if (regs_o[i*8 +: 8] !== exp_r[i]) begin
          fails++;
          $display("FAIL R3/R4/R5/R6 reg%0d actual=%02h expected=%02h", i, regs_o[i*8 +: 8], exp_r[i]);
          break;
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (exp_sub) begin
      sub_m = {4'h0, b[3:0]};
      exp_sub = 1'b0;
    end else begin
      if (sub_m < NREG) exp_r[sub_m] = b;
      exp_sub = 1'b1;
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0; wait_n(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit is_addr, input bit clip_hit, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_n(H);
      scl_m = 1'b1;
      if (i == 0 && !is_addr && active) begin
        repeat (3) @(posedge clk);
        #1 model_byte(b);
        wait_n(H - 2);
      end else begin
        wait_n(H);
      end
      scl_m = 1'b0;
    end
    if (is_addr) begin
      active  = (b == 8'h84);
      exp_sub = 1'b1;
    end
    sda_m = 1'b1; wait_n(H);
    acked = (sda_line == 1'b0);
    scl_m = 1'b1; wait_n(H);
    scl_m = 1'b0;
    if (clip_hit) begin
      wait_n(2); clip_evt = 1'b1;
      wait_n(1); clip_evt = 1'b0;
      wait_n(H - 3);
    end else begin
      wait_n(H);
    end
  endtask

  task automatic write_tel(input logic [7:0] bytes [], input bit exp_ack, input string req);
    bit a;
    bus_start();
    foreach (bytes[k]) begin
      send_byte(bytes[k], k == 0, 1'b0, a);
      check(req, {7'b0, a}, {7'b0, exp_ack});
    end
    bus_stop();
    active = 1'b0;
  endtask

  task automatic read_status(input bit hit, input string req);
    bit a;
    logic [7:0] v, e;
    e = {stereo_det, dual_det, 3'b000, exp_clip, 2'b00};
    bus_start();
    send_byte(8'h85, 1'b1, hit, a);
    check("R2 read address ack", {7'b0, a}, 8'h01);
    exp_clip = hit;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(H); scl_m = 1'b1;
      wait_n(H / 2); v[i] = sda_line;
      wait_n(H / 2); scl_m = 1'b0;
    end
    wait_n(H); scl_m = 1'b1; wait_n(H); scl_m = 1'b0; wait_n(H);
    bus_stop();
    check(req, v, e);
  endtask

  task automatic pulse_clip();
    clip_evt = 1'b1; wait_n(1); clip_evt = 1'b0;
    exp_clip = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h01;
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    // R1: reset state
    check("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
    for (int i = 0; i < NREG; i++) check("R1 reset value", regs_o[i*8 +: 8], 8'h01);
    // R3 and R9: single pair, every byte acked
    write_tel('{8'h84, 8'h03, 8'h08}, 1'b1, "R9 ack on write");
    check("R3 reg3", regs_o[3*8 +: 8], 8'h08);
    // R3 upper nibble ignored, R4 several pairs
    write_tel('{8'h84, 8'hF1, 8'h3F, 8'h02, 8'h2A, 8'h08, 8'h45}, 1'b1, "R9 ack multi");
    check("R3 upper nibble ignored", regs_o[1*8 +: 8], 8'h3F);
    check("R4 second pair", regs_o[2*8 +: 8], 8'h2A);
    check("R4 third pair", regs_o[8*8 +: 8], 8'h45);
    // R5: no auto-increment
    write_tel('{8'h84, 8'h03, 8'h10, 8'h09, 8'h0A}, 1'b1, "R9 ack R5 telegram");
    check("R5 reg3", regs_o[3*8 +: 8], 8'h10);
    check("R5 reg4 untouched", regs_o[4*8 +: 8], 8'h01);
    check("R5 reg9", regs_o[9*8 +: 8], 8'h0A);
    // R6: out-of-range subaddress acked, discarded
    write_tel('{8'h84, 8'h0C, 8'h55}, 1'b1, "R6 ack out of range");
    check("R6 reg0 unchanged", regs_o[0*8 +: 8], 8'h01);
    // R2: foreign address ignored
    write_tel('{8'h86, 8'h00, 8'h77}, 1'b0, "R2 no ack foreign address");
    check("R2 reg0 unchanged", regs_o[0*8 +: 8], 8'h01);
    // R10: START restarts pairing
    write_tel('{8'h84, 8'h05}, 1'b1, "R10 lone subaddress ack");
    write_tel('{8'h84, 8'h06, 8'h12}, 1'b1, "R10 ack");
    check("R10 reg6", regs_o[6*8 +: 8], 8'h12);
    check("R10 reg5 untouched", regs_o[5*8 +: 8], 8'h01);
    // R7: status layout
    stereo_det = 1'b1; dual_det = 1'b0;
    read_status(1'b0, "R7 stereo status");
    // R8: clip sticky, cleared by read
    stereo_det = 1'b0; dual_det = 1'b1;
    pulse_clip();
    wait_n(50);
    read_status(1'b0, "R8 clip reported");
    read_status(1'b0, "R8 clip cleared");
    // R8: clip in capture cycle survives
    pulse_clip();
    read_status(1'b1, "R8 clip before collision");
    read_status(1'b0, "R8 clip kept after collision");
    read_status(1'b0, "R8 clip cleared again");
    wait_n(10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule